// File: doc/BRIEF.md
# Control Transfer Record Ring Buffer

This block keeps a history of control transfers, such as branches, calls, returns and traps. Each record holds a source address, a target address and a type code. The records live in a circular array whose active size is a power of two. Software never sees raw slot numbers. It sees a shifting list in which logical entry 0 is always the newest record, entry 1 the one before it, and so on.

An upstream qualifier decides whether an event is worth recording. It presents an already-qualified event to the block, together with a flag for return-stack emulation. When that flag is set, return events remove the newest record and coroutine swaps replace it, so that the array behaves like a call stack. A register-select port reads any logical entry, and the read data appears one cycle after the select. The block also holds the write pointer and applies the depth configuration.

Top module: `ctr_ring`

## Requirements
- R1: The active depth is 16 << `depth_cfg`. Any `depth_cfg` value above `MAX_CFG` (default 2) counts as `MAX_CFG`, which gives depths of 16, 32 and 64 with the defaults.
- R2: An accepted normal event writes the slot at (`wr_ptr` & (depth-1)). `wr_ptr` then becomes that slot plus one, modulo the depth.
- R3: A select value of 0x200+n reads logical entry n, which sits at physical slot (`wr_ptr` - n - 1) & (depth-1). Entry 0 is the newest record. The data appears on the outputs one clock after the select.
- R4: A select below 0x200, or one with n at or above the active depth, returns zero on all three read outputs.
- R5: A written source word holds bit 0 = 1 (the valid bit) with the event's source in bits above it. The target word holds bit 0 = 0 (the mispredict flag). The data word holds the type code in its low `TYPE_W` bits and zeros everywhere else.
- R6: When `ev_rasemu` is 1, an event of type 6 (return) writes nothing. It moves the pointer back by one, modulo the depth, and clears the valid bit of the slot the pointer then names.
- R7: When `ev_rasemu` is 1, an event of type 15 (coroutine swap) rewrites the slot just below the pointer, which is logical entry 0. The pointer stays where it was.
- R8: When `ev_rasemu` is 0, types 6 and 15 are stored as ordinary records.
- R9: While `frozen` is 1, an event neither writes, pops nor moves the pointer.
- R10: Reset sets `wr_ptr` to 0 and clears every valid bit.
- R11: A read of the slot that is being written in the same cycle returns the contents the slot held before the write.
- R12: A change of `depth_cfg` leaves `wr_ptr` and the stored slots untouched. The new mask applies from the next event and the next read. Slots at or beyond a smaller depth keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Qualified event strobe |
| ev_src | input | AW | Source address of the event |
| ev_dst | input | AW | Target address of the event |
| ev_type | input | TYPE_W | Record type code |
| ev_rasemu | input | 1 | Return-stack emulation mode |
| frozen | input | 1 | Frozen status; blocks all updates |
| depth_cfg | input | CFG_W | Depth configuration |
| rd_sel | input | SEL_W | Register select for reads |
| rd_src | output | AW | Source word of the selected entry |
| rd_dst | output | AW | Target word of the selected entry |
| rd_data | output | DATA_W | Data word of the selected entry |
| wr_ptr | output | PTR_W | Current write pointer |

## Verification
The bench wraps the pointer at depth 16 and at depth 64. It then reads the newest and oldest logical entries; a design with an off-by-one error in the remap would return a neighbouring record. It pops and swaps in emulation mode and checks both the pointer and the cleared valid bit. A design that popped the wrong slot, or moved the pointer on a swap, would show a stale entry 0. It also reads a slot in the very cycle that slot is written, and shrinks and then regrows the depth. A design with write-first forwarding, or one that cleared or masked slots eagerly, would return new or lost data.

// File: rtl/ctr_ring_pkg.sv
package ctr_ring_pkg;
  localparam int unsigned SEL_BASE = 32'h200;
  localparam logic [3:0] TYPE_RETURN = 4'd6;
  localparam logic [3:0] TYPE_SWAP   = 4'd15;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_PUSH,
    EV_POP,
    EV_SWAP
  } ev_kind_e;
endpackage

// File: rtl/ctr_ring_ptr.sv
module ctr_ring_ptr
  import ctr_ring_pkg::*;
#(
  parameter int CFG_W   = 3,
  parameter int MAX_CFG = 2,
  parameter int TYPE_W  = 4,
  parameter int PTR_W   = 4 + MAX_CFG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [TYPE_W-1:0] ev_type,
  input  logic              ev_rasemu,
  input  logic              frozen,
  input  logic [CFG_W-1:0]  depth_cfg,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  act_mask,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_slot,
  output logic              clr_en,
  output logic [PTR_W-1:0]  clr_slot
);
  localparam logic [TYPE_W-1:0] RET_CODE  = TYPE_W'(TYPE_RETURN);
  localparam logic [TYPE_W-1:0] SWAP_CODE = TYPE_W'(TYPE_SWAP);

  ev_kind_e       kind;
  logic [PTR_W:0] depth_full;
  logic [PTR_W-1:0] base, prev, next, ptr_nxt;
  int unsigned    cfg_eff;

  // R1: clamp the configuration and derive the mask
  always_comb begin
    cfg_eff    = (int'(depth_cfg) > MAX_CFG) ? MAX_CFG : int'(depth_cfg);
    depth_full = (PTR_W+1)'(16) << cfg_eff;
    act_mask   = PTR_W'(depth_full - 1'b1);
  end

  // Event classification (R6, R7, R8, R9)
  always_comb begin
    if (!ev_valid || frozen)                   kind = EV_NONE;
    else if (ev_rasemu && ev_type == RET_CODE)  kind = EV_POP;
    else if (ev_rasemu && ev_type == SWAP_CODE) kind = EV_SWAP;
    else                                       kind = EV_PUSH;
  end

  // R12: the mask is applied to the pointer only when an event arrives
  always_comb begin
    base     = wr_ptr & act_mask;
    prev     = (base - 1'b1) & act_mask;
    next     = (base + 1'b1) & act_mask;
    wr_en    = (kind == EV_PUSH) || (kind == EV_SWAP);
    wr_slot  = (kind == EV_SWAP) ? prev : base;
    clr_en   = (kind == EV_POP);
    clr_slot = prev;
    unique case (kind)
      EV_PUSH: ptr_nxt = next;
      EV_POP:  ptr_nxt = prev;
      EV_SWAP: ptr_nxt = base;
      default: ptr_nxt = wr_ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) wr_ptr <= '0;
    else     wr_ptr <= ptr_nxt;
  end
endmodule

// File: rtl/ctr_ring_remap.sv
module ctr_ring_remap
  import ctr_ring_pkg::*;
#(
  parameter int SEL_W = 12,
  parameter int PTR_W = 6
) (
  input  logic [SEL_W-1:0] rd_sel,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] act_mask,
  output logic [PTR_W-1:0] rd_idx,
  output logic             rd_hit
);
  logic [SEL_W-1:0] offset;

  // R3, R4: logical-to-physical remap and range check
  always_comb begin
    offset = rd_sel - SEL_W'(SEL_BASE);
    rd_hit = (rd_sel >= SEL_W'(SEL_BASE)) && (offset <= SEL_W'(act_mask));
    rd_idx = (wr_ptr - offset[PTR_W-1:0] - 1'b1) & act_mask;
  end
endmodule

// File: rtl/ctr_ring_store.sv
module ctr_ring_store #(
  parameter int AW     = 32,
  parameter int TYPE_W = 4,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_slot,
  input  logic [AW-1:0]     wr_src,
  input  logic [AW-1:0]     wr_dst,
  input  logic [TYPE_W-1:0] wr_type,
  input  logic              clr_en,
  input  logic [PTR_W-1:0]  clr_slot,
  input  logic [PTR_W-1:0]  rd_idx,
  input  logic              rd_hit,
  output logic [AW-1:0]     rd_src,
  output logic [AW-1:0]     rd_dst,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NSLOT = 1 << PTR_W;

  logic [AW-2:0]     src_mem [NSLOT];
  logic [AW-2:0]     dst_mem [NSLOT];
  logic [TYPE_W-1:0] typ_mem [NSLOT];
  logic [NSLOT-1:0]  vld;

  logic [AW-2:0]     src_q, dst_q;
  logic [TYPE_W-1:0] typ_q;
  logic              vld_q, hit_q;

  // Array writes and read-first registered reads (R11)
  always_ff @(posedge clk) begin
    if (wr_en) begin
      src_mem[wr_slot] <= wr_src[AW-1:1];
      dst_mem[wr_slot] <= wr_dst[AW-1:1];
      typ_mem[wr_slot] <= wr_type;
    end
    src_q <= src_mem[rd_idx];
    dst_q <= dst_mem[rd_idx];
    typ_q <= typ_mem[rd_idx];
  end

  // Valid bits: set on write, cleared on pop, reset to zero (R5, R6, R10)
  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      vld_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      if (wr_en)       vld[wr_slot]  <= 1'b1;
      else if (clr_en) vld[clr_slot] <= 1'b0;
      vld_q <= vld[rd_idx];
      hit_q <= rd_hit;
    end
  end

  // Output word formatting (R4, R5)
  always_comb begin
    rd_src  = hit_q ? {src_q, vld_q} : '0;
    rd_dst  = hit_q ? {dst_q, 1'b0}  : '0;
    rd_data = hit_q ? DATA_W'(typ_q) : '0;
  end
endmodule

// File: rtl/ctr_ring.sv
module ctr_ring #(
  parameter int AW      = 32,
  parameter int TYPE_W  = 4,
  parameter int DATA_W  = 32,
  parameter int CFG_W   = 3,
  parameter int MAX_CFG = 2,
  parameter int SEL_W   = 12,
  parameter int PTR_W   = 4 + MAX_CFG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [AW-1:0]     ev_src,
  input  logic [AW-1:0]     ev_dst,
  input  logic [TYPE_W-1:0] ev_type,
  input  logic              ev_rasemu,
  input  logic              frozen,
  input  logic [CFG_W-1:0]  depth_cfg,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [AW-1:0]     rd_src,
  output logic [AW-1:0]     rd_dst,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  wr_ptr
);
  logic [PTR_W-1:0] act_mask, wr_slot, clr_slot, rd_idx;
  logic             wr_en, clr_en, rd_hit;

  ctr_ring_ptr #(
    .CFG_W(CFG_W), .MAX_CFG(MAX_CFG), .TYPE_W(TYPE_W), .PTR_W(PTR_W)
  ) u_ptr (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_type(ev_type),
    .ev_rasemu(ev_rasemu), .frozen(frozen), .depth_cfg(depth_cfg),
    .wr_ptr(wr_ptr), .act_mask(act_mask), .wr_en(wr_en), .wr_slot(wr_slot),
    .clr_en(clr_en), .clr_slot(clr_slot)
  );

  ctr_ring_remap #(
    .SEL_W(SEL_W), .PTR_W(PTR_W)
  ) u_remap (
    .rd_sel(rd_sel), .wr_ptr(wr_ptr), .act_mask(act_mask),
    .rd_idx(rd_idx), .rd_hit(rd_hit)
  );

  ctr_ring_store #(
    .AW(AW), .TYPE_W(TYPE_W), .DATA_W(DATA_W), .PTR_W(PTR_W)
  ) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_src(ev_src), .wr_dst(ev_dst), .wr_type(ev_type),
    .clr_en(clr_en), .clr_slot(clr_slot), .rd_idx(rd_idx), .rd_hit(rd_hit),
    .rd_src(rd_src), .rd_dst(rd_dst), .rd_data(rd_data)
  );
endmodule

// File: rtl/ctr_ring_chk.sv
module ctr_ring_chk #(
  parameter int AW     = 32,
  parameter int TYPE_W = 4,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 12,
  parameter int PTR_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic [TYPE_W-1:0] ev_type,
  input logic              ev_rasemu,
  input logic              frozen,
  input logic [SEL_W-1:0]  rd_sel,
  input logic [AW-1:0]     rd_src,
  input logic [AW-1:0]     rd_dst,
  input logic [DATA_W-1:0] rd_data,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic [PTR_W-1:0]  act_mask
);
  logic is_ret, is_swap;
  assign is_ret  = ev_type == TYPE_W'(6);
  assign is_swap = ev_type == TYPE_W'(15);

  assert_reset_ptr_R10: assert property (@(posedge clk)
    rst |=> wr_ptr == '0);

  assert_push_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !frozen && !ev_rasemu)
      |=> wr_ptr == ((($past(wr_ptr) & $past(act_mask)) + 1'b1) & $past(act_mask)));

  assert_pop_back_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !frozen && ev_rasemu && is_ret)
      |=> wr_ptr == ((($past(wr_ptr) & $past(act_mask)) - 1'b1) & $past(act_mask)));

  assert_swap_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !frozen && ev_rasemu && is_swap)
      |=> wr_ptr == ($past(wr_ptr) & $past(act_mask)));

  assert_frozen_hold_R9: assert property (@(posedge clk) disable iff (rst)
    frozen |=> $stable(wr_ptr));

  assert_low_sel_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_sel < SEL_W'(12'h200)) |=> (rd_src == '0 && rd_dst == '0 && rd_data == '0));
endmodule

bind ctr_ring ctr_ring_chk #(
  .AW(AW), .TYPE_W(TYPE_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_type(ev_type),
  .ev_rasemu(ev_rasemu), .frozen(frozen), .rd_sel(rd_sel),
  .rd_src(rd_src), .rd_dst(rd_dst), .rd_data(rd_data),
  .wr_ptr(wr_ptr), .act_mask(act_mask)
);

// File: tb/ctr_ring_tb.sv
`timescale 1ns/1ps
module ctr_ring_tb;
  localparam int AW = 32, TW = 4, DW = 32, CW = 3, MAXC = 2, SW = 12, PW = 6;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_valid = 1'b0;
  logic [AW-1:0] ev_src = '0, ev_dst = '0;
  logic [TW-1:0] ev_type = '0;
  logic          ev_rasemu = 1'b0, frozen = 1'b0;
  logic [CW-1:0] depth_cfg = '0;
  logic [SW-1:0] rd_sel = 12'h200;
  logic [AW-1:0] rd_src, rd_dst;
  logic [DW-1:0] rd_data;
  logic [PW-1:0] wr_ptr;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] m_src [NS];
  logic [AW-1:0] m_dst [NS];
  logic [TW-1:0] m_typ [NS];
  bit            m_val [NS];
  bit            m_wr  [NS];
  int            m_wp = 0;

  always #5 clk = ~clk;

  ctr_ring u_dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_src(ev_src), .ev_dst(ev_dst),
    .ev_type(ev_type), .ev_rasemu(ev_rasemu), .frozen(frozen), .depth_cfg(depth_cfg),
    .rd_sel(rd_sel), .rd_src(rd_src), .rd_dst(rd_dst), .rd_data(rd_data), .wr_ptr(wr_ptr)
  );

  function automatic int mdepth();
    return 16 << ((int'(depth_cfg) > MAXC) ? MAXC : int'(depth_cfg));
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_apply(logic [AW-1:0] s, logic [AW-1:0] d, logic [TW-1:0] t, bit ras);
    int mask, base, slot;
    if (frozen) return;
    mask = mdepth() - 1;
    base = m_wp & mask;
    if (ras && t == 4'd6) begin
      slot = (base - 1) & mask;
      m_val[slot] = 1'b0;
      m_wp = slot;
    end else begin
      slot = (ras && t == 4'd15) ? ((base - 1) & mask) : base;
      m_src[slot] = s; m_dst[slot] = d; m_typ[slot] = t;
      m_val[slot] = 1'b1; m_wr[slot] = 1'b1;
      m_wp = (slot + 1) & mask;
    end
  endtask

  task automatic ev(logic [AW-1:0] s, logic [AW-1:0] d, logic [TW-1:0] t, bit ras);
    @(negedge clk);
    ev_valid = 1'b1; ev_src = s; ev_dst = d; ev_type = t; ev_rasemu = ras;
    @(negedge clk);
    ev_valid = 1'b0; ev_rasemu = 1'b0;
    model_apply(s, d, t, ras);
  endtask

  task automatic expect_sel(logic [SW-1:0] sel, string req);
    int n, idx, dep;
    logic [AW-1:0] es, ed;
    logic [DW-1:0] edat;
    bit full;
    dep = mdepth();
    n = int'(sel) - 32'h200;
    if (int'(sel) < 32'h200 || n >= dep) begin
      es = '0; ed = '0; edat = '0; full = 1'b1;
    end else begin
      idx = (m_wp - n - 1) & (dep - 1);
      es = {m_src[idx][AW-1:1], m_val[idx]};
      ed = {m_dst[idx][AW-1:1], 1'b0};
      edat = DW'(m_typ[idx]);
      full = m_wr[idx];
    end
    if (full) begin
      check(rd_src == es, req, "rd_src", 64'(rd_src), 64'(es));
      check(rd_dst == ed, req, "rd_dst", 64'(rd_dst), 64'(ed));
      check(rd_data == edat, req, "rd_data", 64'(rd_data), 64'(edat));
    end else begin
      check(rd_src[0] == es[0], req, "valid", 64'(rd_src[0]), 64'(es[0]));
    end
  endtask

  task automatic chk_sel(logic [SW-1:0] sel, string req);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    expect_sel(sel, req);
  endtask

  task automatic chk_wp(string req);
    @(negedge clk);
    check(wr_ptr == PW'(m_wp), req, "wr_ptr", 64'(wr_ptr), 64'(m_wp));
  endtask

  task automatic t_reset();
    chk_wp("R10");
    chk_sel(12'h200, "R10");
  endtask

  task automatic t_fill();
    depth_cfg = 3'd0;
    for (int i = 0; i < 20; i++)
      ev(32'h1000 + i * 16 + 1, 32'h8000_0001 + i * 32, TW'(i % 16), 1'b0);
    chk_wp("R2");
    chk_sel(12'h200, "R3");
    chk_sel(12'h201, "R5");
    chk_sel(12'h20F, "R3");
    chk_sel(12'h20D, "R8");
    chk_sel(12'h204, "R8");
  endtask

  task automatic t_oob();
    chk_sel(12'h1FF, "R4");
    chk_sel(12'h210, "R4");
    chk_sel(12'h2FF, "R4");
  endtask

  task automatic t_ras();
    ev(32'hA000_0000, 32'hB000_0000, 4'd9, 1'b1);
    ev(32'hA100_0000, 32'hB100_0000, 4'd9, 1'b1);
    chk_wp("R2");
    ev(32'h0, 32'h0, 4'd6, 1'b1);
    chk_wp("R6");
    chk_sel(12'h200, "R6");
    chk_sel(12'h20F, "R6");
    ev(32'hC200_0000, 32'hD200_0000, 4'd15, 1'b1);
    chk_wp("R7");
    chk_sel(12'h200, "R7");
    chk_sel(12'h201, "R7");
  endtask

  task automatic t_freeze();
    frozen = 1'b1;
    ev(32'hEEEE_0000, 32'hEEEE_0000, 4'd2, 1'b0);
    ev(32'h0, 32'h0, 4'd6, 1'b1);
    chk_wp("R9");
    chk_sel(12'h200, "R9");
    frozen = 1'b0;
  endtask

  task automatic t_rdw();
    logic [SW-1:0] sel;
    sel = SW'(32'h200 + mdepth() - 1);
    @(negedge clk);
    rd_sel = sel;
    ev_valid = 1'b1; ev_src = 32'h5555_0000; ev_dst = 32'h6666_0000;
    ev_type = 4'd3; ev_rasemu = 1'b0;
    @(negedge clk);
    ev_valid = 1'b0;
    expect_sel(sel, "R11");
    model_apply(32'h5555_0000, 32'h6666_0000, 4'd3, 1'b0);
    chk_sel(12'h200, "R11");
  endtask

  task automatic t_depth();
    int left;
    depth_cfg = 3'd2;
    left = 64 - m_wp;
    for (int i = 0; i < left; i++)
      ev(32'h2_0000 + i * 4, 32'h3_0000 + i * 4, TW'(i % 5), 1'b0);
    chk_wp("R1");
    depth_cfg = 3'd7;
    for (int i = 0; i < 23; i++)
      ev(32'h4_0000 + i * 4, 32'h5_0000 + i * 4, 4'd1, 1'b0);
    chk_wp("R1");
    chk_sel(12'h23F, "R1");
    chk_sel(12'h240, "R1");
    depth_cfg = 3'd0;
    chk_wp("R12");
    ev(32'h7777_0000, 32'h7777_1000, 4'd4, 1'b0);
    chk_wp("R12");
    chk_sel(12'h200, "R12");
    depth_cfg = 3'd2;
    chk_sel(12'h233, "R12");
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      m_src[i] = '0; m_dst[i] = '0; m_typ[i] = '0; m_val[i] = 1'b0; m_wr[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill();
    t_oob();
    t_ras();
    t_freeze();
    t_rdw();
    t_depth();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule